// File: doc/BRIEF.md
# Parallel Memory Bus Strobe Decoder

This block sits behind the pins of a byte-wide parallel memory port. It watches three active-low control lines: chip select, output enable and write enable. These lines arrive with no relation to the system clock. The block brings them into the clock domain and turns them into two kinds of result. For reads, it produces a level that turns on the external data bus driver and a one-clock request pulse for the storage array. For writes, it produces byte-load events for the program sequencer, each carrying a captured address and data byte.

A write is made by two enables, chip select and write enable, and either one can act as the strobe. The block treats the pair as one combined strobe that is active while both are low. The address is taken when the combined strobe begins, which is the later of the two falling edges. The data is taken when the combined strobe ends, which is the first of the two rising edges. A write is accepted only if output enable stays high for the whole strobe. The tristate buffer is at the chip top; this block only gives it its enable.

Top module: `pbus_strobe_decoder`

## Requirements
- R1: After reset, `dq_oe`, `rd_en` and `ld_valid` are low.
- R2: Once chip select and output enable are low and write enable is high, `dq_oe` goes high within four clocks. `rd_en` pulses high for exactly one clock at the start of each such read access.
- R3: `dq_oe` is low whenever chip select is high, output enable is high, or write enable is low. All eight level combinations of the three lines obey this rule.
- R4: Holding chip select low and pulsing write enable low, with output enable high, gives one byte load. That load carries the address and data that were applied.
- R5: Holding write enable low and pulsing chip select low, with output enable high, gives one byte load. That load carries the address and data that were applied.
- R6: `ld_addr` is the address present when the second of the two enables falls. Address changes before that fall, or after it while the strobe is active, do not appear in the load.
- R7: `ld_data` is the data present when the first of the two enables rises. Data changes after that rise do not appear in the load.
- R8: Each combined strobe gives at most one `ld_valid` pulse, and the pulse is exactly one clock wide.
- R9: No byte load is emitted if output enable is low at any sampled point while the combined strobe is active. This holds both when output enable is low from the start and when it drops in the middle of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_cs_n | input | 1 | Chip select from the pin, active low |
| bus_oe_n | input | 1 | Output enable from the pin, active low |
| bus_we_n | input | 1 | Write enable from the pin, active low |
| bus_addr | input | ADDR_W | Address lines from the pins |
| bus_din | input | DATA_W | Data lines from the pins (input side of the bidirectional bus) |
| rd_en | output | 1 | One-clock array read request at the start of a read access |
| dq_oe | output | 1 | Enable for the top-level data bus tristate driver |
| ld_valid | output | 1 | One-clock byte-load event |
| ld_addr | output | ADDR_W | Address captured at the start of the combined strobe |
| ld_data | output | DATA_W | Data captured at the end of the combined strobe |

## Verification
Suppose the strobe's edge state or its acceptance flag goes wrong. The ports then show a missing or doubled `ld_valid` pulse, or a load with the wrong address or data byte. This appears about three clocks after the strobe ends. A capture point taken from the wrong edge shows up only when address or data change between the two enable edges. For that reason the bench drives both enable orders with values that differ across the gap. A wrong read gate shows in `dq_oe` a few clocks after a level change, and the bench checks all eight control combinations.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/read_gate.sv
module read_gate
  import strobe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t ctl,
  output logic rd_en,
  output logic dq_oe
);

  logic rd_cond;
  logic oe_nx, rd_nx;

  assign rd_cond = !ctl.cs_n && !ctl.oe_n && ctl.we_n;

  always_comb begin
    oe_nx = rd_cond;
    rd_nx = rd_cond && !dq_oe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe <= 1'b0;
      rd_en <= 1'b0;
    end else begin
      dq_oe <= oe_nx;
      rd_en <= rd_nx;
    end
  end

  // R3: any deselecting level turns the driver off on the next clock
  a_r3_hiz_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cs_n || ctl.oe_n || !ctl.we_n) |=> !dq_oe);

  // R2: the array request only comes with the driver on
  a_r2_rd_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> dq_oe);

  // R2: the request is a single clock
  a_r2_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

endmodule

// File: rtl/strobe_capture.sv
module strobe_capture
  import strobe_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              ld_valid,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data
);

  logic act, act_q, fall, rise;
  logic armed_q, armed_nx, vld_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [DATA_W-1:0] data_nx;

  assign act  = !ctl.cs_n && !ctl.we_n;
  assign fall = act && !act_q;
  assign rise = !act && act_q;

  always_comb begin
    addr_nx  = ld_addr;
    data_nx  = ld_data;
    armed_nx = armed_q;
    vld_nx   = 1'b0;
    if (fall) begin
      addr_nx  = addr_s;
      armed_nx = ctl.oe_n;
    end else if (act && !ctl.oe_n) begin
      armed_nx = 1'b0;
    end
    if (act) data_nx = data_s;
    if (rise) begin
      vld_nx   = armed_q && ctl.oe_n;
      armed_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      armed_q  <= 1'b0;
      ld_valid <= 1'b0;
      ld_addr  <= '0;
      ld_data  <= '0;
    end else begin
      act_q    <= act;
      armed_q  <= armed_nx;
      ld_valid <= vld_nx;
      ld_addr  <= addr_nx;
      ld_data  <= data_nx;
    end
  end

  // R8: a load event never lasts beyond one clock
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid);

  // R6: address frozen while the strobe stays active
  a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (act && act_q) |=> $stable(ld_addr));

  // R7: data frozen while no strobe is active
  a_r7_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !act_q) |=> $stable(ld_data));

  // R9: output enable seen low inside a strobe blocks the event
  a_r9_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !ctl.oe_n) |=> !ld_valid);

endmodule

// File: rtl/pbus_strobe_decoder.sv
module pbus_strobe_decoder
  import strobe_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic              rd_en,
  output logic              dq_oe,
  output logic              ld_valid,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data
);

  localparam int BUS_W = ADDR_W + DATA_W;

  logic [1:0] rst_pipe_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  ctl_t ctl_raw, ctl_s;
  logic [BUS_W-1:0] bus_s;

  assign ctl_raw = '{cs_n: bus_cs_n, oe_n: bus_oe_n, we_n: bus_we_n};

  sync_bank #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst_n(srst_n), .d(ctl_raw), .q(ctl_s)
  );

  sync_bank #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(srst_n), .d({bus_addr, bus_din}), .q(bus_s)
  );

  read_gate u_read (
    .clk(clk), .rst_n(srst_n), .ctl(ctl_s), .rd_en(rd_en), .dq_oe(dq_oe)
  );

  strobe_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(srst_n), .ctl(ctl_s),
    .addr_s(bus_s[BUS_W-1:DATA_W]), .data_s(bus_s[DATA_W-1:0]),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  // R3: the bus is never driven in the clock a load is reported
  a_r3_no_drive_on_load: assert property (@(posedge clk) disable iff (!srst_n)
    !(dq_oe && ld_valid));

endmodule

// File: tb/pbus_strobe_decoder_test.sv
`timescale 1ns/1ps
module pbus_strobe_decoder_test;

  localparam int AW = 6;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic rd_en, dq_oe, ld_valid;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;

  int checks = 0, errors = 0;
  int ld_cnt = 0, rd_cnt = 0;
  logic [AW-1:0] cap_a = '0;
  logic [DW-1:0] cap_d = '0;
  logic prev_v = 1'b0, wide = 1'b0;

  always #4 clk = ~clk;

  pbus_strobe_decoder #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_din(din), .rd_en(rd_en), .dq_oe(dq_oe),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  always @(negedge clk) begin
    if (ld_valid) begin
      ld_cnt <= ld_cnt + 1;
      cap_a  <= ld_addr;
      cap_d  <= ld_data;
    end
    if (rd_en) rd_cnt <= rd_cnt + 1;
    if (ld_valid && prev_v) wide <= 1'b1;
    prev_v <= ld_valid;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic we_load(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; din = d; oe_n = 1'b1; cs_n = 1'b0; wn(4);
    we_n = 1'b0; wn(4);
    we_n = 1'b1; wn(4);
    cs_n = 1'b1; wn(4);
  endtask

  task automatic cs_load(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; din = d; oe_n = 1'b1; we_n = 1'b0; wn(4);
    cs_n = 1'b0; wn(4);
    cs_n = 1'b1; wn(4);
    we_n = 1'b1; wn(4);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    wn(3);
    check("R1 dq_oe", dq_oe, 0);
    check("R1 rd_en", rd_en, 0);
    check("R1 ld_valid", ld_valid, 0);
    rst_n = 1'b1;
    wn(5);
    check("R1 dq_oe after release", dq_oe, 0);

    // R2 read access
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; wn(5);
    check("R2 dq_oe on read", dq_oe, 1);
    check("R2 one rd_en", rd_cnt, 1);
    wn(10);
    check("R2 rd_en not repeated", rd_cnt, 1);
    oe_n = 1'b1; wn(5);
    oe_n = 1'b0; wn(5);
    check("R2 second access pulse", rd_cnt, 2);
    cs_n = 1'b1; oe_n = 1'b1; wn(5);

    // R3 every level combination
    for (int k = 0; k < 8; k++) begin
      cs_n = k[2]; oe_n = k[1]; we_n = k[0];
      wn(5);
      check($sformatf("R3 combo %0d", k), dq_oe, (k == 1) ? 1 : 0);
    end
    cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; wn(6);

    // R4 sweep over every address, write-enable strobe
    for (int a = 0; a < 64; a++) begin
      logic [DW-1:0] d;
      d = DW'((a * 5 + 3) % 16);
      base = ld_cnt;
      we_load(AW'(a), d);
      check("R4 count", ld_cnt - base, 1);
      check("R4 addr", cap_a, a);
      check("R4 data", cap_d, d);
    end

    // R5 sweep over every data value, chip-select strobe
    for (int d = 0; d < 16; d++) begin
      base = ld_cnt;
      cs_load(AW'(63 - d), DW'(d));
      check("R5 count", ld_cnt - base, 1);
      check("R5 addr", cap_a, 63 - d);
      check("R5 data", cap_d, d);
    end

    // R6 R7 write enable falls first, chip select falls last and rises first
    base = ld_cnt;
    oe_n = 1'b1; addr = 6'd11; din = 4'd1;
    we_n = 1'b0; wn(4);
    addr = 6'd22; wn(4);
    cs_n = 1'b0; wn(4);
    addr = 6'd33; din = 4'd9; wn(4);
    cs_n = 1'b1; wn(4);
    din = 4'd5; addr = 6'd44; wn(4);
    we_n = 1'b1; wn(6);
    check("R6 later fall addr (cs last)", cap_a, 22);
    check("R7 first rise data (cs first)", cap_d, 9);
    check("R8 one pulse per strobe", ld_cnt - base, 1);

    // R6 R7 chip select falls first, write enable falls last and rises first
    base = ld_cnt;
    addr = 6'd7; din = 4'd2;
    cs_n = 1'b0; wn(4);
    addr = 6'd50; wn(4);
    we_n = 1'b0; wn(4);
    addr = 6'd3; din = 4'd12; wn(4);
    we_n = 1'b1; wn(4);
    din = 4'd6; wn(4);
    cs_n = 1'b1; wn(6);
    check("R6 later fall addr (we last)", cap_a, 50);
    check("R7 first rise data (we first)", cap_d, 12);
    check("R8 one pulse per strobe b", ld_cnt - base, 1);

    // R9 output enable low through the strobe
    base = ld_cnt;
    addr = 6'd1; din = 4'd1; oe_n = 1'b0;
    cs_n = 1'b0; wn(4);
    we_n = 1'b0; wn(4);
    we_n = 1'b1; wn(4);
    cs_n = 1'b1; oe_n = 1'b1; wn(6);
    check("R9 oe low whole strobe", ld_cnt - base, 0);

    // R9 output enable drops mid strobe
    base = ld_cnt;
    cs_n = 1'b0; wn(4);
    we_n = 1'b0; wn(4);
    oe_n = 1'b0; wn(4);
    oe_n = 1'b1; wn(4);
    we_n = 1'b1; wn(4);
    cs_n = 1'b1; wn(6);
    check("R9 oe dip mid strobe", ld_cnt - base, 0);

    base = ld_cnt;
    we_load(6'd42, 4'd13);
    check("R9 recovery count", ld_cnt - base, 1);
    check("R9 recovery addr", cap_a, 42);
    check("R9 recovery data", cap_d, 13);

    check("R8 pulse width", wide, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule